// File: doc/BRIEF.md
# Processor Bus Memory Responder

This block sits on the external bus of an 8-bit microprocessor and acts as its memory. It watches four active-low strobes: a memory-request strobe, a read strobe, a write strobe and an I/O-request strobe. It also watches an address bus and an 8-bit data bus. The block synchronises the strobes into its own clock domain. It answers memory reads from an internal byte array and stores memory writes into that array. While it serves a read it raises a flag. The data bus is bidirectional at the pads. At this block's edge it appears as a separate input byte, an output byte and an output enable, and the pad cell combines them.

A memory read needs the memory-request and read strobes low together. A refresh cycle pulls only the memory-request strobe low, and the block must not answer it. Any cycle with the I/O-request strobe low is not a memory access and is ignored. The lowest addresses, up to and including a boundary parameter, form a read-only region. This region is loaded at reset from a parameter image, and writes to it are discarded. When either the memory-request strobe or the read strobe returns high, the flag and the bus drive drop within the same clock period, before any synchroniser stage. This lets the processor reuse the bus at once.

Top module: `busMemResponder`

## Requirements
- R1: With I/O-request high, memory-request and read strobes falling together between clocks make readActive and dataOe go high on the third rising clock edge after the fall, not earlier. dataOut then carries the byte stored at the address present on that edge.
- R2: A refresh cycle (memory-request low, read high) never raises readActive or dataOe, whatever its length.
- R3: readActive and dataOe go low combinationally, within the same clock period, as soon as either the memory-request or the read strobe goes high.
- R4: dataOut is all zeros whenever dataOe is low. dataOe is high only while readActive is high.
- R5: A write cycle (memory-request and write strobes low, I/O-request high) stores dataIn at addr into the array on the third rising edge after the write strobe falls. Address and data are sampled on that edge, and only one store happens per fall of the write strobe.
- R6: A write to any address less than or equal to ROM_LAST is dropped. A later read of that address returns the preloaded byte.
- R7: After reset, byte i of the array equals bits [8i+7:8i] of ROM_IMAGE for i up to ROM_LAST, and every other byte is zero.
- R8: While the I/O-request strobe is low, no read is started and no write is stored, even if the other strobes are low.
- R9: While reset is low and right after it is released, readActive, dataOe and dataOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| mreqN | input | 1 | Memory-request strobe, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| iorqN | input | 1 | I/O-request strobe, active low, asynchronous |
| addr | input | ADDR_W | Processor address bus |
| dataIn | input | 8 | Byte sampled from the data pads during writes |
| dataOut | output | 8 | Byte driven onto the data pads during reads |
| dataOe | output | 1 | Data pad output enable |
| readActive | output | 1 | High while a memory read is being served |

## Verification
Two functions can land on the same clock edge. One is the end of a read, where the controller leaves its read state. The other is the commit of a write. The bench provokes this by holding the memory-request strobe low and, in a single step, releasing the read strobe and dropping the write strobe. Both synchronised changes then reach the controller on the same edge. The bench judges the result in three ways. The bus must release at once. The per-clock model must agree on every output. A following read of that address must return the newly written byte, so neither action can mask the other.

// File: rtl/busMemPkg.sv
package busMemPkg;
  localparam int DATA_W = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } rdState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic startRead;  // latch the addressed byte for the bus
    logic commitWr;   // store dataIn at addr
  } busCtl_t;
endpackage

// File: rtl/busSync.sv
module busSync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawIn,
  output logic [N-1:0] syncOut
);
  // two-stage synchroniser per strobe, idle value is high (inactive)
  for (genvar g = 0; g < N; g++) begin : gBit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1 <= 1'b1;
        stage2 <= 1'b1;
      end else begin
        stage1 <= rawIn[g];
        stage2 <= stage1;
      end
    end
    assign syncOut[g] = stage2;
  end
endmodule

// File: rtl/busCtl.sv
module busCtl
  import busMemPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    mreqS,
  input  logic    rdS,
  input  logic    wrS,
  input  logic    iorqS,
  output busCtl_t ctl,
  output logic    reading
);
  rdState_t state, stateNext;
  logic wrPrev;
  logic readCond, memCycle;

  assign memCycle = !mreqS && iorqS;
  assign readCond = memCycle && !rdS;

  always_comb begin
    stateNext     = state;
    ctl.startRead = 1'b0;
    unique case (state)
      ST_IDLE: if (readCond) begin
        stateNext     = ST_READ;
        ctl.startRead = 1'b1;
      end
      ST_READ: if (!readCond) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    // one store per synchronised falling edge of the write strobe
    ctl.commitWr = wrPrev && !wrS && memCycle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrPrev <= 1'b1;
    end else begin
      state  <= stateNext;
      wrPrev <= wrS;
    end
  end

  assign reading = (state == ST_READ);
endmodule

// File: rtl/busDatapath.sv
module busDatapath
  import busMemPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ROM_LAST = 15,
  parameter logic [8*(ROM_LAST+1)-1:0] ROM_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdByte
);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int ROM_BITS  = 8 * (ROM_LAST + 1);

  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic writable;

  function automatic logic [DATA_W-1:0] romByte(input int idx);
    logic [ROM_BITS-1:0] shifted;
    shifted = ROM_IMAGE >> (8 * idx);
    return (idx <= ROM_LAST) ? shifted[DATA_W-1:0] : '0;
  endfunction

  assign writable = int'(addr) > ROM_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= romByte(i);
    end else if (ctl.commitWr && writable) begin
      mem[addr] <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdByte <= '0;
    else if (ctl.startRead) rdByte <= mem[addr];
  end
endmodule

// File: rtl/busMemResponder.sv
module busMemResponder
  import busMemPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ROM_LAST = 15,
  parameter logic [8*(ROM_LAST+1)-1:0] ROM_IMAGE = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mreqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              iorqN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              readActive
);
  logic [3:0]  syncS;
  busCtl_t     ctl;
  logic        reading;
  logic [7:0]  rdByte;

  busSync #(.N(4)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({iorqN, wrN, rdN, mreqN}),
    .syncOut(syncS)
  );

  busCtl uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .mreqS  (syncS[0]),
    .rdS    (syncS[1]),
    .wrS    (syncS[2]),
    .iorqS  (syncS[3]),
    .ctl    (ctl),
    .reading(reading)
  );

  busDatapath #(
    .ADDR_W   (ADDR_W),
    .ROM_LAST (ROM_LAST),
    .ROM_IMAGE(ROM_IMAGE)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .addr  (addr),
    .dataIn(dataIn),
    .rdByte(rdByte)
  );

  // raw strobes gate the drive so the bus is released without synchroniser delay
  assign readActive = reading && !mreqN && !rdN;
  assign dataOe     = readActive;
  assign dataOut    = dataOe ? rdByte : 8'h00;
endmodule

// File: rtl/busMemChecker.sv
module busMemChecker (
  input logic       clk,
  input logic       rstN,
  input logic       mreqN,
  input logic       rdN,
  input logic       iorqN,
  input logic       readActive,
  input logic       dataOe,
  input logic [7:0] dataOut
);
  // R1: the flag only rises after both strobes were low for two edges
  a_r1_rise_after_sync: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readActive) |-> ($past(!mreqN && !rdN) && $past(!mreqN && !rdN, 2)));

  // R3: a released strobe leaves no flag behind
  a_r3_release: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdN) || $rose(mreqN)) |-> !readActive);

  // R4: idle bus carries zeros
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

  // R8: an I/O cycle held for three edges never drives the bus
  a_r8_io_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && $past(!iorqN) && $past(!iorqN, 2) && $past(!iorqN, 3)) |-> !dataOe);
endmodule

bind busMemResponder busMemChecker uChk (.*);

// File: tb/sim_busMemResponder.sv
module sim_busMemResponder;
  localparam logic [127:0] ROM_IMG = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  localparam int ROM_END = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mreqN = 1'b1, rdN = 1'b1, wrN = 1'b1, iorqN = 1'b1;
  logic [7:0] addr = '0, dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe, readActive;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busMemResponder #(.ADDR_W(8), .ROM_LAST(ROM_END), .ROM_IMAGE(ROM_IMG)) u0 (
    .clk(clk), .rstN(rstN), .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .iorqN(iorqN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .readActive(readActive)
  );

  function automatic int romVal(int i);
    return int'((ROM_IMG >> (8 * i)) & 128'hff);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int mm [256];
  int hist [$];          // raw strobe samples, newest at the back
  bit mReading = 0, mPrevWr = 1;
  int mByte = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mm[i] = (i <= ROM_END) ? romVal(i) : 0;
      hist = {4'b1111, 4'b1111};
      mReading = 0; mPrevWr = 1; mByte = 0;
    end else begin
      logic [3:0] s;   // {iorq, wr, rd, mreq}, value two edges old
      bit rc;
      s  = hist[0];
      rc = !s[0] && !s[1] && s[3];
      if (!mReading && rc) begin mReading = 1; mByte = mm[addr]; end
      else if (mReading && !rc) mReading = 0;
      if (mPrevWr && !s[2] && !s[0] && s[3] && int'(addr) > ROM_END) mm[addr] = int'(dataIn);
      mPrevWr = s[2];
      void'(hist.pop_front());
      hist.push_back({iorqN, wrN, rdN, mreqN});
      #5;
      begin
        bit expAct;
        expAct = mReading && !mreqN && !rdN;
        check("R3 flag vs model", int'(readActive), int'(expAct));
        check("R4 enable vs model", int'(dataOe), int'(expAct));
        check("R1 data vs model", int'(dataOut), expAct ? mByte : 0);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doRead(input int a, output int got);
    @(negedge clk);
    addr = 8'(a); mreqN = 0; rdN = 0;
    idle(4);
    got = int'(dataOut);
    mreqN = 1; rdN = 1;
    #1 check("R3 release after read", int'(dataOe), 0);
    idle(3);
  endtask

  task automatic doWrite(input int a, input int d);
    @(negedge clk);
    addr = 8'(a); dataIn = 8'(d); mreqN = 0; wrN = 0;
    idle(4);
    mreqN = 1; wrN = 1;
    idle(3);
  endtask

  initial begin
    int got;
    idle(3);
    check("R9 flag in reset", int'(readActive), 0);
    check("R9 enable in reset", int'(dataOe), 0);
    check("R9 data in reset", int'(dataOut), 0);
    rstN = 1;
    idle(2);
    check("R9 flag after reset", int'(readActive), 0);

    // R1 latency
    @(negedge clk);
    addr = 8'd5; mreqN = 0; rdN = 0;
    @(negedge clk); check("R1 no flag after 1 edge", int'(readActive), 0);
    @(negedge clk); check("R1 no flag after 2 edges", int'(readActive), 0);
    @(negedge clk); check("R1 flag on 3rd edge", int'(readActive), 1);
    check("R1 byte of ROM addr 5", int'(dataOut), romVal(5));
    rdN = 1;
    #1 check("R3 flag drops on read strobe", int'(readActive), 0);
    check("R4 bus released", int'(dataOe), 0);
    mreqN = 1;
    idle(3);

    // R7 preload and cleared RAM
    doRead(0, got);  check("R7 ROM addr 0", got, romVal(0));
    doRead(15, got); check("R7 ROM last addr", got, romVal(15));
    doRead(128, got); check("R7 RAM zero", got, 0);

    // R2 refresh
    @(negedge clk);
    addr = 8'd3; mreqN = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 refresh flag", int'(readActive), 0);
      check("R2 refresh enable", int'(dataOe), 0);
    end
    mreqN = 1;
    idle(3);

    // R5 writes, several patterns
    doWrite(8'h40, 8'h5c);
    doWrite(8'hff, 8'ha3);
    doWrite(16, 8'h01);
    doRead(8'h40, got); check("R5 readback 0x40", got, 8'h5c);
    doRead(8'hff, got); check("R5 readback top addr", got, 8'ha3);
    doRead(16, got);    check("R5 first RAM addr", got, 8'h01);

    // R5 long write strobe stores once: data change after commit is not taken
    @(negedge clk);
    addr = 8'h41; dataIn = 8'h11; mreqN = 0; wrN = 0;
    idle(4);
    dataIn = 8'h99;
    idle(4);
    mreqN = 1; wrN = 1;
    idle(3);
    doRead(8'h41, got); check("R5 single store per strobe", got, 8'h11);

    // R6 ROM protection
    doWrite(2, 8'hee);
    doWrite(ROM_END, 8'h77);
    doRead(2, got);       check("R6 ROM addr 2 kept", got, romVal(2));
    doRead(ROM_END, got); check("R6 ROM boundary kept", got, romVal(ROM_END));

    // R8 I/O cycles ignored
    @(negedge clk);
    iorqN = 0; addr = 8'h50; dataIn = 8'haa; mreqN = 0; wrN = 0;
    idle(5);
    wrN = 1; rdN = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 I/O read not served", int'(dataOe), 0);
    end
    rdN = 1; mreqN = 1; iorqN = 1;
    idle(3);
    doRead(8'h50, got); check("R8 I/O write not stored", got, 0);

    // read end and write commit on the same edge
    @(negedge clk);
    addr = 8'h40; mreqN = 0; rdN = 0;
    idle(4);
    check("R1 read before turnaround", int'(dataOut), 8'h5c);
    rdN = 1; wrN = 0; dataIn = 8'h77;
    #1 check("R3 release on turnaround", int'(dataOe), 0);
    idle(5);
    mreqN = 1; wrN = 1;
    idle(3);
    doRead(8'h40, got); check("R5 write after read end", got, 8'h77);

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule